// File: doc/BRIEF.md
# Scan-Chain Command Bridge to On-Chip Bus

This block is a test data register placed behind a standard JTAG TAP. A debugger shifts in a 49-bit command holding a direction flag, a 16-bit bus address and a 32-bit data word. When the TAP passes through Update-DR while the bridge's instruction is selected, the command is replayed as one request/acknowledge transaction on an on-chip functional bus. Each instrument on that bus answers at its own base address, so one short register reaches many instruments.

On the next Capture-DR the register loads the read data returned by the last transaction, together with status flags. The debugger reads these out on the following shift. Between captures the register is a plain 49-stage shift segment, so it can share a scan chain with other test data registers. The bus side runs on TCK. The TAP controller supplies the one-cycle capture, shift and update strobes and the instruction-select level.

Top module: `tdr_bus_bridge`

## Requirements
- R1: After reset the bus request is low, TDO is 0, and a capture with no transaction since reset loads all 49 bits as 0.
- R2: While selected and shifting, each TCK moves the register one place toward TDO, so a bit leaves TDO 49 shift cycles after it entered on TDI. Capture contents leave bit 0 first.
- R3: Once 49 bits are shifted, the first bit shifted lands in bit 0. Bits 31:0 are the data word, bits 47:32 the address, and bit 48 (the last bit shifted) the direction, where 1 means write and 0 means read.
- R4: An update while selected and idle raises the request on the next TCK, with address, direction and write data taken from the register. These stay stable while the request is high.
- R5: A write transaction drives the data field on the write-data bus. Once acknowledged, the next capture shows bit 48 (completed) as 1 and bit 33 (timed out) as 0.
- R6: A read transaction stores the bus read data present at the acknowledge, and the next capture loads it into bits 31:0.
- R7: The request stays high until an acknowledge is sampled and drops on the following TCK, so a responder that answers after L waiting cycles sees the request high for L+1 cycles.
- R8: With no acknowledge, the request is high for exactly 255 cycles and then drops. The next capture shows bit 33 = 1 and bit 48 = 0.
- R9: With the instruction not selected, capture, shift and update strobes change neither the register contents nor the bus.
- R10: An update that arrives while a transaction is pending is ignored, leaving the bus address unchanged. It sets a sticky overrun flag, which capture reports in bit 34. A capture clears this flag after loading it.
- R11: A capture taken while a transaction is pending reports bit 32 (busy) as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock, also clocks the bus master |
| trst_n | input | 1 | Active-low asynchronous reset |
| instr_sel_i | input | 1 | Bridge instruction currently selected |
| capture_dr_i | input | 1 | One-cycle Capture-DR strobe |
| shift_dr_i | input | 1 | Shift-DR level |
| update_dr_i | input | 1 | One-cycle Update-DR strobe |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out (register bit 0) |
| bus_req_o | output | 1 | Transaction request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 16 | Transaction address |
| bus_wdata_o | output | 32 | Write data |
| bus_ack_i | input | 1 | Transaction acknowledge |
| bus_rdata_i | input | 32 | Read data, valid with acknowledge |

## Verification
Every cycle, the assertions check the bus handshake. Request attributes stay stable while the request is high. The request falls right after an acknowledge and never outlives the 255-cycle limit. No request appears without a selected update, and a selected update from idle always starts one. The scenarios are the only way to show the serial side: field placement and shift order, what capture loads, read data making the trip from bus to TDO, the sticky overrun being set and then cleared by capture, and unselected strobes leaving the stored contents untouched.

// File: rtl/tdr_bridge_pkg.sv
package tdr_bridge_pkg;
    // Bus master sequencing
    typedef enum logic {
        MST_IDLE = 1'b0,
        MST_WAIT = 1'b1
    } mst_state_e;

    // Capture-word bit offsets above the data field
    localparam int STAT_BUSY_OFS = 0;
    localparam int STAT_TMO_OFS  = 1;
    localparam int STAT_OVR_OFS  = 2;
    localparam int STAT_BITS     = 3;
endpackage

// File: rtl/tdr_scan_reg.sv
module tdr_scan_reg #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int LEN   = ADDR_W + DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              capture_i,
    input  logic              shift_i,
    input  logic              tdi_i,
    input  logic [LEN-1:0]    cap_word_i,
    output logic              tdo_o,
    output logic              cmd_rw_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic [DATA_W-1:0] cmd_data_o
);
    typedef struct packed {
        logic [LEN-1:0] sr;
    } scan_state_t;

    scan_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel_i) begin
            if (capture_i) begin
                st_d.sr = cap_word_i;
            end else if (shift_i) begin
                st_d.sr = {tdi_i, st_q.sr[LEN-1:1]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tdo_o      = st_q.sr[0];
    assign cmd_data_o = st_q.sr[DATA_W-1:0];
    assign cmd_addr_o = st_q.sr[DATA_W +: ADDR_W];
    assign cmd_rw_o   = st_q.sr[LEN-1];
endmodule

// File: rtl/tdr_bus_master.sv
module tdr_bus_master
    import tdr_bridge_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int TMO_CYC = 255,
    localparam int CNT_W  = $clog2(TMO_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              clr_ovr_i,
    input  logic              cmd_rw_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [DATA_W-1:0] cmd_data_i,
    input  logic              bus_ack_i,
    input  logic [DATA_W-1:0] bus_rdata_i,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    output logic              stat_busy_o,
    output logic              stat_ok_o,
    output logic              stat_tmo_o,
    output logic              stat_ovr_o,
    output logic [DATA_W-1:0] rd_data_o
);
    typedef struct packed {
        mst_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              ok;
        logic              tmo;
        logic              ovr;
    } mst_t;

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CYC - 1);

    mst_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (clr_ovr_i) m_d.ovr = 1'b0;
        unique case (m_q.state)
            MST_IDLE: begin
                if (start_i) begin
                    m_d.state = MST_WAIT;
                    m_d.cnt   = '0;
                    m_d.we    = cmd_rw_i;
                    m_d.addr  = cmd_addr_i;
                    m_d.wdata = cmd_data_i;
                    m_d.ok    = 1'b0;
                    m_d.tmo   = 1'b0;
                end
            end
            MST_WAIT: begin
                if (start_i) m_d.ovr = 1'b1;
                if (bus_ack_i) begin
                    if (!m_q.we) m_d.rdata = bus_rdata_i;
                    m_d.ok    = 1'b1;
                    m_d.state = MST_IDLE;
                end else if (m_q.cnt == CNT_LAST) begin
                    m_d.tmo   = 1'b1;
                    m_d.state = MST_IDLE;
                end else begin
                    m_d.cnt = m_q.cnt + 1'b1;
                end
            end
            default: m_d.state = MST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign bus_req_o   = (m_q.state == MST_WAIT);
    assign bus_we_o    = m_q.we;
    assign bus_addr_o  = m_q.addr;
    assign bus_wdata_o = m_q.wdata;
    assign stat_busy_o = (m_q.state == MST_WAIT);
    assign stat_ok_o   = m_q.ok;
    assign stat_tmo_o  = m_q.tmo;
    assign stat_ovr_o  = m_q.ovr;
    assign rd_data_o   = m_q.rdata;
endmodule

// File: rtl/tdr_bus_bridge.sv
module tdr_bus_bridge
    import tdr_bridge_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int TMO_CYC = 255,
    localparam int LEN    = ADDR_W + DATA_W + 1,
    localparam int PAD_W  = ADDR_W - STAT_BITS
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              instr_sel_i,
    input  logic              capture_dr_i,
    input  logic              shift_dr_i,
    input  logic              update_dr_i,
    input  logic              tdi_i,
    output logic              tdo_o,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic              bus_ack_i,
    input  logic [DATA_W-1:0] bus_rdata_i
);
    logic              cmd_rw;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    logic              st_busy, st_ok, st_tmo, st_ovr;
    logic [DATA_W-1:0] rd_data;
    logic [LEN-1:0]    cap_word;
    logic [STAT_BITS-1:0] stat_vec;

    always_comb begin
        stat_vec                = '0;
        stat_vec[STAT_BUSY_OFS] = st_busy;
        stat_vec[STAT_TMO_OFS]  = st_tmo;
        stat_vec[STAT_OVR_OFS]  = st_ovr;
        cap_word = {st_ok, {PAD_W{1'b0}}, stat_vec, rd_data};
    end

    tdr_scan_reg #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) scan_i (
        .clk        (tck),
        .rst_n      (trst_n),
        .sel_i      (instr_sel_i),
        .capture_i  (capture_dr_i),
        .shift_i    (shift_dr_i),
        .tdi_i      (tdi_i),
        .cap_word_i (cap_word),
        .tdo_o      (tdo_o),
        .cmd_rw_o   (cmd_rw),
        .cmd_addr_o (cmd_addr),
        .cmd_data_o (cmd_data)
    );

    tdr_bus_master #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .TMO_CYC(TMO_CYC)
    ) mst_i (
        .clk        (tck),
        .rst_n      (trst_n),
        .start_i    (instr_sel_i & update_dr_i),
        .clr_ovr_i  (instr_sel_i & capture_dr_i),
        .cmd_rw_i   (cmd_rw),
        .cmd_addr_i (cmd_addr),
        .cmd_data_i (cmd_data),
        .bus_ack_i  (bus_ack_i),
        .bus_rdata_i(bus_rdata_i),
        .bus_req_o  (bus_req_o),
        .bus_we_o   (bus_we_o),
        .bus_addr_o (bus_addr_o),
        .bus_wdata_o(bus_wdata_o),
        .stat_busy_o(st_busy),
        .stat_ok_o  (st_ok),
        .stat_tmo_o (st_tmo),
        .stat_ovr_o (st_ovr),
        .rd_data_o  (rd_data)
    );
endmodule

// File: rtl/tdr_bus_bridge_chk.sv
module tdr_bus_bridge_chk #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int TMO_CYC = 255,
    localparam int CNT_W  = $clog2(TMO_CYC + 2)
) (
    input logic              tck,
    input logic              trst_n,
    input logic              instr_sel_i,
    input logic              update_dr_i,
    input logic              bus_req_o,
    input logic              bus_we_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic [DATA_W-1:0] bus_wdata_o,
    input logic              bus_ack_i
);
    // Cycles the request has already been high before the current one
    logic [CNT_W-1:0] run_q;
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)        run_q <= '0;
        else if (bus_req_o) run_q <= run_q + 1'b1;
        else                run_q <= '0;
    end

    p_req_stable_r4: assert property (@(posedge tck) disable iff (!trst_n)
        bus_req_o |=> (!bus_req_o || ($stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_wdata_o))));

    p_start_r4: assert property (@(posedge tck) disable iff (!trst_n)
        (instr_sel_i && update_dr_i && !bus_req_o) |=> bus_req_o);

    p_drop_after_ack_r7: assert property (@(posedge tck) disable iff (!trst_n)
        (bus_req_o && bus_ack_i) |=> !bus_req_o);

    p_timeout_drop_r8: assert property (@(posedge tck) disable iff (!trst_n)
        (bus_req_o && run_q == CNT_W'(TMO_CYC - 1)) |=> !bus_req_o);

    p_run_bound_r8: assert property (@(posedge tck) disable iff (!trst_n)
        run_q <= CNT_W'(TMO_CYC));

    p_no_spurious_r9: assert property (@(posedge tck) disable iff (!trst_n)
        (!bus_req_o && !(instr_sel_i && update_dr_i)) |=> !bus_req_o);
endmodule

bind tdr_bus_bridge tdr_bus_bridge_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .TMO_CYC(TMO_CYC)
) chk_i (
    .tck        (tck),
    .trst_n     (trst_n),
    .instr_sel_i(instr_sel_i),
    .update_dr_i(update_dr_i),
    .bus_req_o  (bus_req_o),
    .bus_we_o   (bus_we_o),
    .bus_addr_o (bus_addr_o),
    .bus_wdata_o(bus_wdata_o),
    .bus_ack_i  (bus_ack_i)
);

// File: tb/tdr_bus_bridge_tb_top.sv
`timescale 1ns/1ps
module tdr_bus_bridge_tb_top;
    localparam int LEN = 49;

    logic        tck = 1'b0;
    logic        trst_n = 1'b0;
    logic        sel = 1'b0, cap = 1'b0, shf = 1'b0, upd = 1'b0, tdi = 1'b0;
    logic        tdo, bus_req, bus_we;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;

    int checks = 0, failures = 0;

    // responder model
    int          ack_lat = 0;
    bit          ack_en = 1'b1;
    logic [31:0] rd_val = '0;
    int          wcnt = 0;
    int          run = 0, last_run = 0;
    bit          saw_req = 1'b0;
    logic [15:0] log_addr = '0;
    logic        log_we = 1'b0;
    logic [31:0] log_wdata = '0;

    always #2.5 tck = ~tck;

    tdr_bus_bridge dut_i (
        .tck(tck), .trst_n(trst_n), .instr_sel_i(sel), .capture_dr_i(cap),
        .shift_dr_i(shf), .update_dr_i(upd), .tdi_i(tdi), .tdo_o(tdo),
        .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
        .bus_wdata_o(bus_wdata), .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata)
    );

    always @(negedge tck) begin
        if (bus_req) begin
            run = run + 1;
            saw_req = 1'b1;
        end else if (run != 0) begin
            last_run = run;
            run = 0;
        end
        if (bus_ack) begin
            bus_ack = 1'b0;
            log_addr = bus_addr; log_we = bus_we; log_wdata = bus_wdata;
        end else if (bus_req && ack_en) begin
            if (wcnt >= ack_lat) begin
                bus_ack = 1'b1; bus_rdata = rd_val; wcnt = 0;
            end else wcnt = wcnt + 1;
        end else wcnt = 0;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_cap();
        @(negedge tck); cap = 1'b1;
        @(negedge tck); cap = 1'b0;
    endtask

    task automatic pulse_upd();
        @(negedge tck); upd = 1'b1;
        @(negedge tck); upd = 1'b0;
    endtask

    task automatic shift_dr(input logic [LEN-1:0] din, output logic [LEN-1:0] dout);
        for (int i = 0; i < LEN; i++) begin
            @(negedge tck);
            dout[i] = tdo;
            tdi = din[i];
            shf = 1'b1;
        end
        @(negedge tck); shf = 1'b0; tdi = 1'b0;
    endtask

    function automatic logic [LEN-1:0] cmd(input logic rw, input logic [15:0] a, input logic [31:0] d);
        return {rw, a, d};
    endfunction

    task automatic wait_idle();
        for (int i = 0; i < 400; i++) begin
            if (!bus_req && !bus_ack) break;
            @(negedge tck);
        end
        @(negedge tck); @(negedge tck);
    endtask

    task automatic t_reset();
        logic [LEN-1:0] o;
        chk(bus_req == 1'b0, "R1 req", bus_req, 0);
        chk(tdo == 1'b0, "R1 tdo", tdo, 0);
        pulse_cap();
        shift_dr('0, o);
        chk(o == '0, "R1 capture", o, 0);
    endtask

    task automatic t_write();
        logic [LEN-1:0] o;
        ack_lat = 3;
        shift_dr(cmd(1'b1, 16'h1234, 32'hCAFE_F00D), o);
        pulse_upd();
        wait_idle();
        chk(log_addr == 16'h1234, "R3 addr field", log_addr, 16'h1234);
        chk(log_we == 1'b1, "R3 write flag", log_we, 1);
        chk(log_wdata == 32'hCAFE_F00D, "R5 wdata", log_wdata, 32'hCAFE_F00D);
        chk(last_run == 4, "R7 req length", last_run, 4);
        pulse_cap();
        shift_dr('0, o);
        chk(o[48] == 1'b1 && o[33] == 1'b0, "R5 status", o[48:32], 17'h10000);
    endtask

    task automatic t_read();
        logic [LEN-1:0] o;
        ack_lat = 0;
        rd_val = 32'h89AB_CDEF;
        shift_dr(cmd(1'b0, 16'hBEEF, 32'h5555_AAAA), o);
        pulse_upd();
        wait_idle();
        chk(log_we == 1'b0 && log_addr == 16'hBEEF, "R4 read attrs", {log_we, log_addr}, 17'h0BEEF);
        chk(last_run == 1, "R7 zero-wait req length", last_run, 1);
        rd_val = 32'h0;
        pulse_cap();
        shift_dr('0, o);
        chk(o[31:0] == 32'h89AB_CDEF, "R6 read data", o[31:0], 32'h89AB_CDEF);
        chk(o[48] == 1'b1, "R6 done bit", o[48], 1);
    endtask

    task automatic t_pass(output logic [LEN-1:0] p2);
        logic [LEN-1:0] o, p1;
        p1 = 49'h1_5A5A_0F0F_3C3C;
        p2 = 49'h0_F00D_1234_8765;
        shift_dr(p1, o);
        shift_dr(p2, o);
        chk(o == p1, "R2 passthrough", o, p1);
    endtask

    task automatic t_unsel(input logic [LEN-1:0] held);
        logic [LEN-1:0] o;
        saw_req = 1'b0;
        sel = 1'b0;
        pulse_cap();
        pulse_upd();
        shift_dr('1, o);
        repeat (5) @(negedge tck);
        chk(saw_req == 1'b0, "R9 no bus cycle", saw_req, 0);
        sel = 1'b1;
        shift_dr('0, o);
        chk(o == held, "R9 contents kept", o, held);
    endtask

    task automatic t_timeout();
        logic [LEN-1:0] o;
        ack_en = 1'b0;
        shift_dr(cmd(1'b0, 16'h00C0, 32'h0), o);
        pulse_upd();
        wait_idle();
        chk(last_run == 255, "R8 timeout length", last_run, 255);
        pulse_cap();
        shift_dr('0, o);
        chk(o[33] == 1'b1 && o[48] == 1'b0, "R8 status", {o[48], o[33]}, 2'b01);
        ack_en = 1'b1;
    endtask

    task automatic t_overrun();
        logic [LEN-1:0] o;
        ack_en = 1'b0;
        shift_dr(cmd(1'b1, 16'hA000, 32'h1), o);
        pulse_upd();
        pulse_cap();
        shift_dr(cmd(1'b1, 16'hB000, 32'h2), o);
        chk(o[32] == 1'b1, "R11 busy bit", o[32], 1);
        chk(o[34] == 1'b0, "R10 no overrun yet", o[34], 0);
        pulse_upd();
        @(negedge tck);
        chk(bus_addr == 16'hA000 && bus_req, "R10 update ignored", bus_addr, 16'hA000);
        wait_idle();
        pulse_cap();
        shift_dr('0, o);
        chk(o[34] == 1'b1, "R10 overrun flag", o[34], 1);
        pulse_cap();
        shift_dr('0, o);
        chk(o[34] == 1'b0, "R10 overrun cleared", o[34], 0);
        ack_en = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [LEN-1:0] held;
        repeat (3) @(negedge tck);
        trst_n = 1'b1;
        sel = 1'b1;
        @(negedge tck);
        t_reset();
        t_write();
        t_read();
        t_pass(held);
        t_unsel(held);
        t_timeout();
        t_overrun();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule